// File: doc/BRIEF.md
# DRAM Idle Low-Power Sequencer

This block watches bus activity at the DFI clock rate and moves the DRAM subsystem into deeper low-power levels as an unbroken idle stretch grows. A saturating counter tracks consecutive idle cycles. It is compared against five programmable thresholds:

- power-down
- self-refresh
- self-refresh with the controller clock gated
- a lite self-refresh power-down (LPDDR4 only)
- standby, where controller, PHY and DRAM clocks are all stopped

Two of the thresholds are counted directly. The three self-refresh thresholds are multiplied by 1024.

When a bus request arrives while a low-power level is active, the block first turns every clock back on for one cycle. It then raises a wake request and holds it until the memory side acknowledges. After that it returns to the active level, and only then does it grant the access.

Top module: `dram_lp_seq`

## Requirements
- R1: After reset, lpLevel is 0, lpEnter is 0, wakeReq is 0, busGrant is 0 and all three clock enables are 1.
- R2: The idle count clears on any cycle with busReq=1 and otherwise grows by one per cycle. lpLevel becomes 1 (power-down) on the edge after the count first equals pdIdle, so pdIdle is compared unscaled.
- R3: Self-refresh (lpLevel 2) is reached when the count is at least srIdle×1024. Self-refresh with the controller clock gated (lpLevel 3) is reached when the count is at least srGateIdle×1024.
- R4: Lite self-refresh power-down (lpLevel 4) is reached when the count is at least srpdIdle×1024, and only while memIsLp4=1. With memIsLp4=0 this level is never chosen.
- R5: Standby (lpLevel 5) is reached when the count is at least stbyIdle, unscaled. In standby, ctlClkEn, phyClkEn and dramClkEn are all 0.
- R6: A threshold of 0 disables its level.
- R7: Among the enabled levels whose threshold has been reached, the deepest one is used. The encoding is 0=active, 1=power-down, 2=self-refresh, 3=self-refresh with controller gate, 4=lite power-down, 5=standby. lpEnter is one-hot, with bit lpLevel-1 set while that level is held, and 0 otherwise.
- R8: While a level is held, ctlClkEn is 0 at levels 3 to 5, and phyClkEn and dramClkEn are 0 at level 5 only.
- R9: A busReq at a nonzero level first gives one cycle with all clocks enabled and wakeReq=0. After that, wakeReq is 1 until wakeAck is sampled high, and lpLevel returns to 0 on that edge.
- R10: busGrant is 1 only when busReq=1, lpLevel=0 and no exit is in progress. A busReq in the cycle a threshold would be reached prevents entry to that level.
- R11: The idle counter saturates at its maximum and never wraps, so a reached level is not lost during very long idle stretches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DFI clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReq | input | 1 | Bus request present this cycle |
| wakeAck | input | 1 | Memory side ready after wake |
| memIsLp4 | input | 1 | Attached memory is LPDDR4 |
| pdIdle | input | THR_W | Power-down threshold, unscaled |
| srIdle | input | THR_W | Self-refresh threshold, ×1024 |
| srGateIdle | input | THR_W | Self-refresh + controller gate threshold, ×1024 |
| srpdIdle | input | THR_W | Lite power-down threshold, ×1024 |
| stbyIdle | input | STBY_W | Standby threshold, unscaled |
| lpLevel | output | 3 | Current low-power level code |
| lpEnter | output | 5 | One-hot enter request per level |
| wakeReq | output | 1 | Exit request to memory side |
| busGrant | output | 1 | Access may proceed |
| ctlClkEn | output | 1 | Controller clock enable |
| phyClkEn | output | 1 | PHY clock enable |
| dramClkEn | output | 1 | DRAM clock enable |

## Verification
Escalation and exit can fall in the same cycle: a bus request can land on exactly the edge at which the idle count would cross a threshold. The bench provokes this by counting idle cycles up to one short of the power-down crossing and then raising busReq. It judges the outcome by requiring lpLevel to stay 0 and busGrant to be high, with no exit sequence started. A second overlap occurs when wakeAck and a fresh busReq arrive together. The random phase mixes these cases and compares every cycle against a bench-side model of the level, the clock enables and the handshake.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [2:0] {
    LV_NONE   = 3'd0,
    LV_PD     = 3'd1,
    LV_SR     = 3'd2,
    LV_SRGATE = 3'd3,
    LV_SRPD   = 3'd4,
    LV_STBY   = 3'd5
  } lpLevel_t;

  typedef enum logic [1:0] {
    PH_RUN    = 2'd0,
    PH_UNGATE = 2'd1,
    PH_WAKE   = 2'd2
  } lpPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } lpStrobe_t;
endpackage

// File: rtl/lp_datapath.sv
module lp_datapath
  import lp_pkg::*;
#(
  parameter int CNT_W    = 20,
  parameter int THR_W    = 8,
  parameter int STBY_W   = 16,
  parameter int SCALE_SH = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  lpStrobe_t         strobe,
  input  logic              memIsLp4,
  input  logic [THR_W-1:0]  pdIdle,
  input  logic [THR_W-1:0]  srIdle,
  input  logic [THR_W-1:0]  srGateIdle,
  input  logic [THR_W-1:0]  srpdIdle,
  input  logic [STBY_W-1:0] stbyIdle,
  output lpLevel_t          target
);
  localparam int NUM     = 5;
  localparam int SCL_W   = THR_W + SCALE_SH;
  localparam int MID_W   = (CNT_W > SCL_W) ? CNT_W : SCL_W;
  localparam int CMP_W   = (MID_W > STBY_W) ? MID_W : STBY_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] idleCnt;
  logic [CMP_W-1:0] cntWide;
  logic [CMP_W-1:0] thr [NUM];
  logic [NUM-1:0]   allowed;
  logic [NUM-1:0]   reached;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               idleCnt <= '0;
    else if (strobe.cntClr)                  idleCnt <= '0;
    else if (strobe.cntInc && idleCnt != CNT_MAX) idleCnt <= idleCnt + 1'b1;
  end

  assign cntWide = CMP_W'(idleCnt);

  always_comb begin
    thr[0] = CMP_W'(pdIdle);
    thr[1] = CMP_W'(srIdle) << SCALE_SH;
    thr[2] = CMP_W'(srGateIdle) << SCALE_SH;
    thr[3] = CMP_W'(srpdIdle) << SCALE_SH;
    thr[4] = CMP_W'(stbyIdle);
    allowed = {1'b1, memIsLp4, 3'b111};
  end

  for (genvar g = 0; g < NUM; g++) begin : gCmp
    assign reached[g] = allowed[g] && (thr[g] != '0) && (cntWide >= thr[g]);
  end

  // ascending scan: the deepest reached level is the one that remains
  always_comb begin
    target = LV_NONE;
    for (int i = 0; i < NUM; i++)
      if (reached[i]) target = lpLevel_t'(3'(i + 1));
  end

  // R2
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClr |=> idleCnt == '0);
  // R11
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idleCnt == CNT_MAX && !strobe.cntClr) |=> idleCnt == CNT_MAX);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntInc && !strobe.cntClr && idleCnt != CNT_MAX) |=> idleCnt == $past(idleCnt) + 1'b1);
endmodule

// File: rtl/lp_control.sv
module lp_control
  import lp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      busReq,
  input  logic      wakeAck,
  input  lpLevel_t  target,
  output lpStrobe_t strobe,
  output lpLevel_t  level,
  output logic [4:0] lpEnter,
  output logic      wakeReq,
  output logic      busGrant,
  output logic      ctlClkEn,
  output logic      phyClkEn,
  output logic      dramClkEn
);
  lpPhase_t phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_RUN;
      level <= LV_NONE;
    end else begin
      case (phase)
        PH_RUN: begin
          if (busReq && level != LV_NONE) phase <= PH_UNGATE;
          else if (!busReq)               level <= target;
        end
        PH_UNGATE: phase <= PH_WAKE;
        PH_WAKE: if (wakeAck) begin
          phase <= PH_RUN;
          level <= LV_NONE;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  always_comb begin
    strobe.cntClr = busReq || (phase != PH_RUN);
    strobe.cntInc = !strobe.cntClr;
    wakeReq  = (phase == PH_WAKE);
    busGrant = busReq && (phase == PH_RUN) && (level == LV_NONE);
    lpEnter  = '0;
    if (phase == PH_RUN && level != LV_NONE) lpEnter[3'(level) - 3'd1] = 1'b1;
    if (phase != PH_RUN) begin
      ctlClkEn  = 1'b1;
      phyClkEn  = 1'b1;
      dramClkEn = 1'b1;
    end else begin
      ctlClkEn  = (level < LV_SRGATE);
      phyClkEn  = (level != LV_STBY);
      dramClkEn = (level != LV_STBY);
    end
  end

  // R9
  ungate_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeReq) |-> $past(ctlClkEn && phyClkEn && dramClkEn && !wakeReq));
  // R9
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReq && !wakeAck) |=> wakeReq);
  // R7
  enter_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lpEnter));
  // R9
  wake_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReq && wakeAck) |=> (level == LV_NONE && !wakeReq));
endmodule

// File: rtl/dram_lp_seq.sv
module dram_lp_seq
  import lp_pkg::*;
#(
  parameter int CNT_W    = 20,
  parameter int THR_W    = 8,
  parameter int STBY_W   = 16,
  parameter int SCALE_SH = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              wakeAck,
  input  logic              memIsLp4,
  input  logic [THR_W-1:0]  pdIdle,
  input  logic [THR_W-1:0]  srIdle,
  input  logic [THR_W-1:0]  srGateIdle,
  input  logic [THR_W-1:0]  srpdIdle,
  input  logic [STBY_W-1:0] stbyIdle,
  output logic [2:0]        lpLevel,
  output logic [4:0]        lpEnter,
  output logic              wakeReq,
  output logic              busGrant,
  output logic              ctlClkEn,
  output logic              phyClkEn,
  output logic              dramClkEn
);
  lpStrobe_t strobe;
  lpLevel_t  target;
  lpLevel_t  level;

  lp_datapath #(.CNT_W(CNT_W), .THR_W(THR_W), .STBY_W(STBY_W), .SCALE_SH(SCALE_SH)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memIsLp4(memIsLp4),
    .pdIdle(pdIdle), .srIdle(srIdle), .srGateIdle(srGateIdle),
    .srpdIdle(srpdIdle), .stbyIdle(stbyIdle), .target(target)
  );

  lp_control uCtl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .wakeAck(wakeAck),
    .target(target), .strobe(strobe), .level(level), .lpEnter(lpEnter),
    .wakeReq(wakeReq), .busGrant(busGrant), .ctlClkEn(ctlClkEn),
    .phyClkEn(phyClkEn), .dramClkEn(dramClkEn)
  );

  assign lpLevel = 3'(level);
endmodule

// File: tb/dram_lp_seq_test.sv
`timescale 1ns/1ps
module dram_lp_seq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReq = 1'b0, wakeAck = 1'b0, memIsLp4 = 1'b0;
  logic [7:0] pdIdle = '0, srIdle = '0, srGateIdle = '0, srpdIdle = '0;
  logic [15:0] stbyIdle = '0;
  logic [2:0] lpLevel, satLevel;
  logic [4:0] lpEnter, satEnter;
  logic wakeReq, busGrant, ctlClkEn, phyClkEn, dramClkEn;
  logic sWake, sGrant, sCtl, sPhy, sDram;

  int nChecks = 0, nFail = 0;
  int mCnt = 0, mLevel = 0, mPhase = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_lp_seq uut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .wakeAck(wakeAck), .memIsLp4(memIsLp4),
    .pdIdle(pdIdle), .srIdle(srIdle), .srGateIdle(srGateIdle), .srpdIdle(srpdIdle),
    .stbyIdle(stbyIdle), .lpLevel(lpLevel), .lpEnter(lpEnter), .wakeReq(wakeReq),
    .busGrant(busGrant), .ctlClkEn(ctlClkEn), .phyClkEn(phyClkEn), .dramClkEn(dramClkEn)
  );

  // narrow counter copy for the saturation case
  dram_lp_seq #(.CNT_W(8)) uutSat (
    .clk(clk), .rstN(rstN), .busReq(busReq), .wakeAck(wakeAck), .memIsLp4(1'b0),
    .pdIdle(8'd200), .srIdle(8'd0), .srGateIdle(8'd0), .srpdIdle(8'd0),
    .stbyIdle(16'd0), .lpLevel(satLevel), .lpEnter(satEnter), .wakeReq(sWake),
    .busGrant(sGrant), .ctlClkEn(sCtl), .phyClkEn(sPhy), .dramClkEn(sDram)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int targetOf(int cnt);
    int t = 0;
    if (pdIdle != 0 && cnt >= pdIdle) t = 1;
    if (srIdle != 0 && cnt >= srIdle * 1024) t = 2;
    if (srGateIdle != 0 && cnt >= srGateIdle * 1024) t = 3;
    if (memIsLp4 && srpdIdle != 0 && cnt >= srpdIdle * 1024) t = 4;
    if (stbyIdle != 0 && cnt >= stbyIdle) t = 5;
    return t;
  endfunction

  task automatic modelStep();
    int oldCnt = mCnt;
    if (!rstN) begin
      mCnt = 0; mLevel = 0; mPhase = 0;
      return;
    end
    if (busReq || mPhase != 0) mCnt = 0;
    else if (mCnt < (1 << 20) - 1) mCnt = mCnt + 1;
    case (mPhase)
      0: if (busReq && mLevel != 0) mPhase = 1;
         else if (!busReq) mLevel = targetOf(oldCnt);
      1: mPhase = 2;
      default: if (wakeAck) begin mPhase = 0; mLevel = 0; end
    endcase
  endtask

  task automatic compareAll();
    int eEnter = (mPhase == 0 && mLevel != 0) ? (1 << (mLevel - 1)) : 0;
    bit eCtl = (mPhase != 0) || (mLevel < 3);
    bit eLow = (mPhase != 0) || (mLevel != 5);
    check(lpLevel == mLevel, "R7 level", lpLevel, mLevel);
    check(lpEnter == eEnter, "R7 enter", lpEnter, eEnter);
    check(ctlClkEn == eCtl && phyClkEn == eLow && dramClkEn == eLow, "R8 clocks",
          {ctlClkEn, phyClkEn, dramClkEn}, {eCtl, eLow, eLow});
    check(wakeReq == (mPhase == 2), "R9 wakeReq", wakeReq, mPhase == 2);
    check(busGrant == (busReq && mPhase == 0 && mLevel == 0), "R10 grant",
          busGrant, busReq && mPhase == 0 && mLevel == 0);
  endtask

  task automatic cyc(input logic b, input logic a);
    busReq = b; wakeAck = a;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0);
  endtask

  // wake the block from any level and return to active
  task automatic wakeUp();
    cyc(1'b1, 1'b0);
    while (wakeReq || (lpLevel != 0)) cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b0);
  endtask

  initial begin
    #1800000;
    nFail++; nChecks++;
    $display("FAIL watchdog actual=hung expected=done");
    if (!done) begin
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check(lpLevel == 0 && lpEnter == 0 && !wakeReq && !busGrant, "R1 outputs", lpLevel, 0);
    check(ctlClkEn && phyClkEn && dramClkEn, "R1 clocks", {ctlClkEn, phyClkEn, dramClkEn}, 7);
    rstN = 1'b1;

    // R2 power-down at pdIdle, unscaled
    pdIdle = 8'd5;
    idle(5);
    check(lpLevel == 0, "R2 before threshold", lpLevel, 0);
    idle(1);
    check(lpLevel == 1 && lpEnter == 5'b00001, "R2 at threshold", lpLevel, 1);
    wakeUp();

    // R10 request on the crossing cycle blocks entry
    idle(5);
    cyc(1'b1, 1'b0);
    check(lpLevel == 0 && busGrant && !wakeReq, "R10 conflict", lpLevel, 0);
    cyc(1'b0, 1'b0);
    check(lpLevel == 0, "R10 no late entry", lpLevel, 0);

    // R3 self-refresh levels, R8 controller gate
    srIdle = 8'd1; srGateIdle = 8'd2; srpdIdle = 8'd3; memIsLp4 = 1'b0;
    idle(1025);
    check(lpLevel == 2 && ctlClkEn, "R3 self-refresh", lpLevel, 2);
    idle(1024);
    check(lpLevel == 3 && !ctlClkEn && phyClkEn && dramClkEn, "R8 ctl gated", lpLevel, 3);
    // R4 lite level not allowed without LPDDR4
    idle(1100);
    check(lpLevel == 3, "R4 no lite without lp4", lpLevel, 3);

    // R9 exit sequence
    cyc(1'b1, 1'b0);
    check(ctlClkEn && phyClkEn && dramClkEn && !wakeReq && lpLevel == 3, "R9 ungate first", lpLevel, 3);
    cyc(1'b0, 1'b0);
    check(wakeReq, "R9 wake raised", wakeReq, 1);
    cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
    check(wakeReq && lpLevel == 3, "R9 wake held", wakeReq, 1);
    cyc(1'b1, 1'b1);
    check(!wakeReq && lpLevel == 0 && busGrant, "R9 back active", lpLevel, 0);

    // R4 lite level with LPDDR4, R5 standby
    memIsLp4 = 1'b1; stbyIdle = 16'd3500;
    idle(3073);
    check(lpLevel == 4 && lpEnter == 5'b01000, "R4 lite level", lpLevel, 4);
    idle(428);
    check(lpLevel == 5 && !ctlClkEn && !phyClkEn && !dramClkEn, "R5 standby", lpLevel, 5);
    wakeUp();

    // R6 zero disables
    pdIdle = 0; srIdle = 0; srGateIdle = 0; srpdIdle = 0; stbyIdle = 0;
    idle(1500);
    check(lpLevel == 0, "R6 all disabled", lpLevel, 0);
    wakeUp();

    // R7 deepest reached wins directly
    pdIdle = 8'd10; stbyIdle = 16'd3;
    idle(4);
    check(lpLevel == 5, "R7 deepest first", lpLevel, 5);
    wakeUp();

    // R11 saturation on the narrow-counter instance
    pdIdle = 0; stbyIdle = 0;
    idle(600);
    check(satLevel == 1 && satEnter == 5'b00001, "R11 no wrap", satLevel, 1);
    wakeUp();

    // random episodes against the model
    for (int ep = 0; ep < 30; ep++) begin
      pdIdle = 8'($urandom % 12);
      srIdle = 8'($urandom % 3);
      srGateIdle = 8'($urandom % 3);
      srpdIdle = 8'($urandom % 3);
      stbyIdle = ($urandom % 2) ? 16'($urandom % 3000) : 16'd0;
      memIsLp4 = 1'($urandom);
      idle(int'($urandom % 3200));
      for (int k = 0; k < 40; k++) begin
        logic b = 1'($urandom % 3 == 0);
        cyc(b, 1'($urandom % 4 == 0));
      end
      while (wakeReq || mPhase != 0) cyc(1'($urandom), 1'b1);
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule